// File: doc/BRIEF.md
# Half-Bridge Protection Control Sequencer

This block decides when a two-channel half-bridge driver may switch. A saturating up/down counter plays the part of a timing capacitor: it charges at a fixed rate and is pulled down by over-current, by an external shutdown request, or by a reset pulse. Two thresholds on this counter split its range into three bands. Below the low threshold the amplifier stage is cut off. Between the two thresholds the amplifier is pre-biased while both gates stay off. At or above the high threshold switching may run, provided nothing else forbids it.

The same counter gives three timings. After reset it sets the power-up delay. After an over-current it sets the self-reset retry time. During shutdown it sets the pre-bias interval. A strap selects latched protection. In that mode an over-current keeps the gates off until a reset pulse of sufficient length arrives. The same pulse is also needed once after power-up.

Supply loss and thermal shutdown cut the gates at once. An external shutdown request instead waits for a quiet-point strobe, or for a bounded timeout, before it stops switching. Every asynchronous input passes through a two-flop synchronizer, and all outputs are registered.

Top module: `hb_prot_seq`

## Requirements
- R1: A high level on any bit of `oc_flag` while the gates are enabled drives `gate_en` low 3 cycles after the flag is applied (2 synchronizer stages plus 1 register). Bit 2c is the high side and bit 2c+1 the low side of channel c.
- R2: With `latch_mode` low, the gates return on their own after an over-current. The off interval lies between ((RAMP_MAX-TH_LO)+(TH_HI-TH_LO))/RATE and that value plus 8 cycles. A persistent over-current repeats the trip and retry cycle.
- R3: After reset release with supplies good, `gate_en` first rises ceil(TH_HI/RATE)+1 cycles later. The gates never turn on while the counter is below TH_HI.
- R4: `mode` encoding: 0 is cut-off (counter below TH_LO), 1 is pre-bias (counter between TH_LO and TH_HI, gates off), 2 is run (gates enabled). The reset state is 0.
- R5: The counter moves by RATE per cycle and saturates at 0 and at RAMP_MAX. RATE therefore scales both the power-up delay and the retry time.
- R6: Either bit of `sup_ok` going low drives `gate_en` low 3 cycles later. Once both bits are high again and the counter is at or above TH_HI, the gates return 3 cycles after the restore.
- R7: With `latch_mode` high, an over-current holds the gates off until `rst_req` has been high for at least RST_MIN cycles. A shorter pulse has no effect. After a valid pulse the counter recharges from 0.
- R8: With `latch_mode` high, the gates stay off after power-up until a valid `rst_req` pulse has been seen.
- R9: A `therm_code` of 2 or 3 (shutdown) drives `gate_en` low 3 cycles later. Codes 0 (normal) and 1 (warning) have no effect on the gates.
- R10: While `ext_sd` is held high, the counter discharges. Once the counter is below TH_HI, the gates turn off one cycle after `quiet_pt` is high, or after SSD_MAX cycles if no strobe arrives. The two stop times therefore differ by SSD_MAX-1 cycles.
- R11: `quiet_pt` has no effect while the counter is at or above TH_HI.
- R12: `fault_n` is low exactly when `gate_en` is low, including during reset.
- R13: If `ext_sd` is held long enough, the counter falls below TH_LO and `mode` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 2*N_CH | Over-current flags, bit 2c high side and 2c+1 low side of channel c |
| ext_sd | input | 1 | External shutdown request, discharges the counter |
| latch_mode | input | 1 | Strap: 1 selects latched protection, 0 selects self-reset |
| rst_req | input | 1 | Protection reset; forces the counter to 0 in latched mode |
| sup_ok | input | N_SUP | Supply-good flags, all must be high to switch |
| therm_code | input | 2 | Thermal status: 0 normal, 1 warning, 2 external sensor shutdown, 3 on-die shutdown |
| quiet_pt | input | 1 | Synchronous strobe marking a quiet point in the switching cycle |
| mode | output | 2 | Amplifier mode: 0 cut-off, 1 pre-bias, 2 run |
| gate_en | output | 1 | Gate enable for both channels |
| fault_n | output | 1 | Active-low fault flag |

## Verification
Two events can land in the same clock cycle: an over-current trip and a supply drop. Because both inputs pass through the same synchronizer depth, the bench applies them on the same edge, so both reach the logic together. At that moment the gates are still enabled, so the over-current must still set the latch rather than be masked by the supply shutdown. The result is judged at the outputs. With the supply restored at once, the gates must stay off for a full discharge and recharge interval. By contrast, a supply drop alone recovers within 3 cycles of the restore.

// File: rtl/hb_prot_pkg.sv
package hb_prot_pkg;

    typedef enum logic [1:0] {
        MODE_CUTOFF  = 2'd0,
        MODE_PREBIAS = 2'd1,
        MODE_RUN     = 2'd2
    } hb_mode_e;

    localparam logic [1:0] THERM_SD_EXT  = 2'd2;
    localparam logic [1:0] THERM_SD_CHIP = 2'd3;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/hb_ramp.sv
module hb_ramp #(
    parameter int RAMP_MAX = 1000,
    parameter int RATE     = 1,
    parameter int LVL_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dn,
    input  logic             zap,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W:0]   TOP_W  = (LVL_W+1)'(RAMP_MAX);
    localparam logic [LVL_W:0]   STEP_W = (LVL_W+1)'(RATE);
    localparam logic [LVL_W-1:0] STEP_N = LVL_W'(RATE);

    logic [LVL_W-1:0] lvl_d, lvl_q;
    logic [LVL_W:0]   sum;

    always_comb begin
        sum = {1'b0, lvl_q} + STEP_W;
        if (zap) begin
            lvl_d = '0;
        end else if (dn) begin
            lvl_d = (lvl_q >= STEP_N) ? (lvl_q - STEP_N) : '0;
        end else if (sum > TOP_W) begin
            lvl_d = TOP_W[LVL_W-1:0];
        end else begin
            lvl_d = sum[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign level = lvl_q;
endmodule

// File: rtl/hb_softstop.sv
module hb_softstop #(
    parameter int SSD_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic quiet,
    output logic stop
);
    localparam int SS_W = $clog2(SSD_MAX + 1);
    localparam logic [SS_W-1:0] LAST = SS_W'(SSD_MAX - 1);

    logic [SS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        stop  = arm && (quiet || (cnt_q == LAST));
        cnt_d = (arm && !stop) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hb_prot_seq.sv
module hb_prot_seq
    import hb_prot_pkg::*;
#(
    parameter int N_CH     = 2,
    parameter int N_SUP    = 2,
    parameter int RAMP_MAX = 1000,
    parameter int TH_LO    = 300,
    parameter int TH_HI    = 700,
    parameter int RATE     = 1,
    parameter int SSD_MAX  = 16,
    parameter int RST_MIN  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*N_CH-1:0] oc_flag,
    input  logic              ext_sd,
    input  logic              latch_mode,
    input  logic              rst_req,
    input  logic [N_SUP-1:0]  sup_ok,
    input  logic [1:0]        therm_code,
    input  logic              quiet_pt,
    output logic [1:0]        mode,
    output logic              gate_en,
    output logic              fault_n
);
    localparam int LVL_W  = $clog2(RAMP_MAX + 1);
    localparam int CNT_W  = $clog2(RST_MIN + 1);
    localparam int N_OC   = 2 * N_CH;
    localparam int SYNC_W = N_OC + 3 + N_SUP + 2;
    localparam logic [LVL_W-1:0] LO_L   = LVL_W'(TH_LO);
    localparam logic [LVL_W-1:0] HI_L   = LVL_W'(TH_HI);
    localparam logic [CNT_W-1:0] RMIN_L = CNT_W'(RST_MIN);

    typedef struct packed {
        logic             ocl;
        logic             armed;
        logic             gate;
        hb_mode_e         mode;
        logic             fault_n;
        logic [CNT_W-1:0] rcnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [N_OC-1:0]  oc_s;
    logic             ext_s, latch_s, rst_s;
    logic [N_SUP-1:0] sup_s;
    logic [1:0]       therm_s;
    logic [LVL_W-1:0] lvl;
    logic             lo_zone, hi_zone, hot_s, trip, kill, rst_done, ramp_dn, ramp_zap;
    logic             ss_arm, ss_stop;

    hb_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({oc_flag, ext_sd, latch_mode, rst_req, sup_ok, therm_code}),
        .dout ({oc_s, ext_s, latch_s, rst_s, sup_s, therm_s})
    );

    hb_ramp #(.RAMP_MAX(RAMP_MAX), .RATE(RATE), .LVL_W(LVL_W)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .dn   (ramp_dn),
        .zap  (ramp_zap),
        .level(lvl)
    );

    hb_softstop #(.SSD_MAX(SSD_MAX)) u_ss (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (ss_arm),
        .quiet(quiet_pt),
        .stop (ss_stop)
    );

    always_comb begin
        lo_zone  = (lvl < LO_L);
        hi_zone  = (lvl >= HI_L);
        hot_s    = (therm_s == THERM_SD_EXT) || (therm_s == THERM_SD_CHIP);
        trip     = (|oc_s) && st_q.gate;
        kill     = trip || st_q.ocl || !(&sup_s) || hot_s;
        rst_done = (st_q.rcnt >= RMIN_L);
        ramp_zap = latch_s && rst_s;
        ramp_dn  = ext_s || (!latch_s && st_q.ocl);
        ss_arm   = st_q.gate && !hi_zone;

        st_d = st_q;

        if (rst_s) st_d.rcnt = (st_q.rcnt == RMIN_L) ? st_q.rcnt : st_q.rcnt + 1'b1;
        else       st_d.rcnt = '0;

        if (latch_s && rst_done && lo_zone) st_d.armed = 1'b1;

        if (trip) begin
            st_d.ocl = 1'b1;
        end else if (st_q.ocl && lo_zone && (!latch_s || rst_done)) begin
            st_d.ocl = 1'b0;
        end

        if (kill) begin
            st_d.gate = 1'b0;
        end else if (st_q.gate) begin
            st_d.gate = !ss_stop;
        end else begin
            st_d.gate = hi_zone && !ext_s && (!latch_s || st_q.armed);
        end

        if (st_d.gate)    st_d.mode = MODE_RUN;
        else if (lo_zone) st_d.mode = MODE_CUTOFF;
        else              st_d.mode = MODE_PREBIAS;

        st_d.fault_n = st_d.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ocl: 1'b0, armed: 1'b0, gate: 1'b0, mode: MODE_CUTOFF,
                      fault_n: 1'b0, rcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign gate_en = st_q.gate;
    assign fault_n = st_q.fault_n;
endmodule

// File: rtl/hb_prot_seq_chk.sv
module hb_prot_seq_chk
    import hb_prot_pkg::*;
#(
    parameter int LVL_W    = 10,
    parameter int N_SUP    = 2,
    parameter int RAMP_MAX = 1000,
    parameter int TH_LO    = 300,
    parameter int TH_HI    = 700
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en,
    input logic [1:0]       mode,
    input logic             ocl_q,
    input logic [N_SUP-1:0] sup_s,
    input logic             hot_s,
    input logic             latch_s,
    input logic             rst_s,
    input logic             quiet_pt,
    input logic [LVL_W-1:0] lvl
);
    localparam logic [LVL_W-1:0] LO_L  = LVL_W'(TH_LO);
    localparam logic [LVL_W-1:0] HI_L  = LVL_W'(TH_HI);
    localparam logic [LVL_W-1:0] TOP_L = LVL_W'(RAMP_MAX);

    AST_LATCH_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ocl_q |-> !gate_en); // R1
    AST_SUPPLY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sup_s) |=> !gate_en); // R6
    AST_HOT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        hot_s |=> !gate_en); // R9
    AST_START_ABOVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(lvl) >= HI_L)); // R3
    AST_PREBIAS_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PREBIAS) |-> (($past(lvl) >= LO_L) && !gate_en)); // R4
    AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= TOP_L); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_s && ocl_q && !rst_s && !$past(rst_s)) |=> ocl_q); // R7
    AST_QUIET_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && quiet_pt && (lvl < HI_L)) |=> !gate_en); // R10
endmodule

bind hb_prot_seq hb_prot_seq_chk #(
    .LVL_W(LVL_W), .N_SUP(N_SUP), .RAMP_MAX(RAMP_MAX), .TH_LO(TH_LO), .TH_HI(TH_HI)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .mode    (mode),
    .ocl_q   (st_q.ocl),
    .sup_s   (sup_s),
    .hot_s   (hot_s),
    .latch_s (latch_s),
    .rst_s   (rst_s),
    .quiet_pt(quiet_pt),
    .lvl     (lvl)
);

// File: tb/hb_prot_seq_test.sv
module hb_prot_seq_test;
    localparam int N_CH = 2, N_SUP = 2, RAMP_MAX = 40, TH_LO = 12, TH_HI = 28;
    localparam int RATE = 1, SSD_MAX = 6, RST_MIN = 4;
    localparam int RETRY_MIN = ((RAMP_MAX - TH_LO) + (TH_HI - TH_LO)) / RATE;
    localparam int PWRUP = (TH_HI + RATE - 1) / RATE + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*N_CH-1:0] oc_flag = '0;
    logic ext_sd = 1'b0, latch_mode = 1'b0, rst_req = 1'b0, quiet_pt = 1'b0;
    logic [N_SUP-1:0] sup_ok = '1;
    logic [1:0] therm_code = 2'd0;
    logic [1:0] mode;
    logic gate_en, fault_n;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    hb_prot_seq #(
        .N_CH(N_CH), .N_SUP(N_SUP), .RAMP_MAX(RAMP_MAX), .TH_LO(TH_LO), .TH_HI(TH_HI),
        .RATE(RATE), .SSD_MAX(SSD_MAX), .RST_MIN(RST_MIN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ext_sd(ext_sd),
        .latch_mode(latch_mode), .rst_req(rst_req), .sup_ok(sup_ok),
        .therm_code(therm_code), .quiet_pt(quiet_pt), .mode(mode),
        .gate_en(gate_en), .fault_n(fault_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_gate(input logic want, input int lim, output int n);
        n = 0;
        while (n < lim) begin
            step(1);
            n++;
            if (gate_en == want) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, t_q, t_n, rises, m10, m20;
        step(3);
        chk(gate_en == 1'b0, "R12 reset gate", int'(gate_en), 0);
        chk(fault_n == 1'b0, "R12 reset fault_n", int'(fault_n), 0);
        chk(mode == 2'd0, "R4 reset mode", int'(mode), 0);
        rst_n = 1'b1;
        n = 0; m10 = -1; m20 = -1;
        while (n < 200) begin
            step(1);
            n++;
            if (n == 10) m10 = int'(mode);
            if (n == 20) m20 = int'(mode);
            if (gate_en) break;
        end
        chk(n == PWRUP, "R3 R5 power-up delay", n, PWRUP);
        chk(m10 == 0, "R4 cut-off band", m10, 0);
        chk(m20 == 1, "R4 pre-bias band", m20, 1);
        chk(mode == 2'd2 && fault_n, "R4 R12 run mode", int'(mode), 2);
        step(RAMP_MAX + 5);

        // quiet strobe outside soft-stop window
        quiet_pt = 1'b1;
        step(10);
        chk(gate_en == 1'b1, "R11 quiet ignored", int'(gate_en), 1);
        ext_sd = 1'b1;
        wait_gate(1'b0, 100, t_q);
        chk(t_q >= (RAMP_MAX - TH_HI) / RATE + 1 && t_q <= (RAMP_MAX - TH_HI) / RATE + 6,
            "R10 quiet stop time", t_q, (RAMP_MAX - TH_HI) / RATE + 3);
        step(2);
        chk(mode == 2'd1, "R4 pre-bias after stop", int'(mode), 1);
        step(50);
        chk(mode == 2'd0, "R13 cut-off under ext_sd", int'(mode), 0);
        chk(fault_n == 1'b0, "R12 fault during ext_sd", int'(fault_n), 0);
        ext_sd = 1'b0; quiet_pt = 1'b0;
        wait_gate(1'b1, 100, n);
        chk(gate_en == 1'b1, "R10 resume after ext_sd", int'(gate_en), 1);
        step(RAMP_MAX + 5);
        ext_sd = 1'b1;
        wait_gate(1'b0, 100, t_n);
        chk(t_n - t_q == SSD_MAX - 1, "R10 timeout vs strobe", t_n - t_q, SSD_MAX - 1);
        ext_sd = 1'b0;
        wait_gate(1'b1, 100, n);
        step(RAMP_MAX + 5);

        // supply sweep
        for (int p = 0; p < 3; p++) begin
            sup_ok = 2'(p);
            step(2);
            chk(gate_en == 1'b1, "R6 not yet off", int'(gate_en), 1);
            step(1);
            chk(gate_en == 1'b0 && fault_n == 1'b0, "R6 supply drop", int'(gate_en), 0);
            sup_ok = '1;
            step(2);
            chk(gate_en == 1'b0, "R6 not yet back", int'(gate_en), 0);
            step(1);
            chk(gate_en == 1'b1, "R6 supply restore", int'(gate_en), 1);
        end

        // thermal sweep
        for (int c = 0; c < 4; c++) begin
            therm_code = 2'(c);
            step(3);
            chk(gate_en == (c < 2), "R9 thermal code", int'(gate_en), int'(c < 2));
            therm_code = 2'd0;
            step(3);
            chk(gate_en == 1'b1, "R9 thermal recover", int'(gate_en), 1);
        end

        // over-current sweep, self-reset mode
        for (int b = 0; b < 2 * N_CH; b++) begin
            oc_flag = '0;
            oc_flag[b] = 1'b1;
            step(2);
            chk(gate_en == 1'b1, "R1 not yet tripped", int'(gate_en), 1);
            step(1);
            chk(gate_en == 1'b0 && fault_n == 1'b0, "R1 trip", int'(gate_en), 0);
            step(2);
            oc_flag = '0;
            wait_gate(1'b1, 120, n);
            chk(n + 2 >= RETRY_MIN && n + 2 <= RETRY_MIN + 8, "R2 R5 retry interval",
                n + 2, RETRY_MIN);
            step(RAMP_MAX + 5);
        end

        // persistent over-current repeats
        oc_flag = 4'b1000;
        rises = 0;
        for (int i = 0; i < 250; i++) begin
            logic prev;
            prev = gate_en;
            step(1);
            if (gate_en && !prev) rises++;
        end
        chk(rises >= 3, "R2 repeated retries", rises, 3);
        oc_flag = '0;
        wait_gate(1'b1, 120, n);
        step(RAMP_MAX + 5);

        // same-cycle supply drop and over-current
        sup_ok = 2'b10;
        oc_flag = 4'b0001;
        step(3);
        chk(gate_en == 1'b0, "R1 R6 coincident off", int'(gate_en), 0);
        sup_ok = '1;
        oc_flag = '0;
        wait_gate(1'b1, 120, n);
        chk(n >= RETRY_MIN && n <= RETRY_MIN + 8, "R1 coincident latch retry", n, RETRY_MIN);

        // latched mode
        rst_n = 1'b0;
        latch_mode = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(80);
        chk(gate_en == 1'b0, "R8 latched needs reset", int'(gate_en), 0);
        chk(mode == 2'd1, "R8 pre-bias while waiting", int'(mode), 1);
        rst_req = 1'b1; step(RST_MIN - 1); rst_req = 1'b0;
        step(80);
        chk(gate_en == 1'b0, "R8 short reset ignored", int'(gate_en), 0);
        rst_req = 1'b1; step(RST_MIN); rst_req = 1'b0;
        wait_gate(1'b1, 100, n);
        chk(gate_en == 1'b1 && n >= TH_HI / RATE, "R8 R7 start after reset", n, TH_HI / RATE);
        step(RAMP_MAX + 5);
        oc_flag = 4'b0100;
        step(3);
        chk(gate_en == 1'b0, "R7 latched trip", int'(gate_en), 0);
        oc_flag = '0;
        step(100);
        chk(gate_en == 1'b0 && fault_n == 1'b0, "R7 latched hold", int'(gate_en), 0);
        chk(mode == 2'd1, "R7 pre-bias in latch", int'(mode), 1);
        rst_req = 1'b1; step(RST_MIN - 1); rst_req = 1'b0;
        step(80);
        chk(gate_en == 1'b0, "R7 short reset ignored", int'(gate_en), 0);
        rst_req = 1'b1; step(RST_MIN); rst_req = 1'b0;
        wait_gate(1'b1, 100, n);
        chk(gate_en == 1'b1 && n >= TH_HI / RATE, "R7 resume after reset", n, TH_HI / RATE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule